// File: doc/BRIEF.md
# TDM Receive Slot Extractor

This block takes a serial audio stream framed by a frame sync and clocked by a bit clock, and returns one parallel mono sample per frame. Two time slots are tracked in every frame. The mono result is one of four things: a slot fixed by a strap input, a programmable left slot, a programmable right slot, or the average of left and right. The fields that set the frame format are static configuration inputs: the edge that starts a frame, the bit-clock edge used for capture, the gap before slot 0, the slot length, the word length and the justification.

The block runs on a fast system clock. It oversamples the bit clock, the frame sync and the data, so the bit clock must run at no more than a quarter of the system clock rate. Bits are numbered from the capture edge that detects the frame start, which is position 0. At the next frame start the words captured during the finished frame are checked against that frame's measured length. The selected result is then registered and presented with a one-cycle strobe. The result is zero for any slot that does not fit inside the frame.

Top module: `tdm_rx_slot_extract`

## Requirements
- R1: After reset, sample_o is zero and sample_valid_o is low. No strobe is issued until one full frame has been received.
- R2: cfg_start_fall_i = 1 starts a frame on a high-to-low frame-sync change. cfg_start_fall_i = 0 starts a frame on a low-to-high change.
- R3: cfg_cap_fall_i = 0 samples frame sync and data on bit-clock rising edges. cfg_cap_fall_i = 1 samples them on falling edges.
- R4: Slot n starts at bit position cfg_offset_i + n * slot length. Position 0 is the bit sampled at the frame-start edge, and the offset can be 0 to 31.
- R5: Slot length codes map as follows: 00 is 16 bits, 01 is 24 bits, 10 is 32 bits. The reserved code 11 is treated as 32 bits.
- R6: Word length codes map as follows: 00 is 16 bits, 01 is 20 bits, 10 is 24 bits, 11 is 32 bits. A word longer than the slot is cut to the slot length. The word leaves the block MSB-aligned in 32 bits, with every bit below it zero.
- R7: cfg_right_just_i = 0 takes the word from the first bits of the slot. cfg_right_just_i = 1 takes it from the last bits of the slot. Bits arrive MSB first.
- R8: cfg_sel_i selects the output. 00 gives the slot numbered strap_slot_i, 01 gives the slot cfg_left_slot_i, and 10 gives the slot cfg_right_slot_i.
- R9: cfg_sel_i = 11 gives (L+R)/2. L and R are read as two's complement, summed in 33 bits and shifted right arithmetically by one.
- R10: A slot that ends after the last bit of the frame gives a zero word. This holds whether the slot overruns the frame partly or fully. A slot that ends exactly on the last bit is kept.
- R11: sample_valid_o is a one-cycle pulse. It is issued once at every frame start after the first, and it carries the frame that just ended. sample_o changes only in the cycle of a strobe.
- R12: Frames of 64, 128, 192 and 256 bits are handled. This covers 2, 4 and 8 slots of 32 bits, and 8 slots of 24 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least four times the bit clock rate |
| rst_n | input | 1 | Synchronous active-low reset |
| bclk_i | input | 1 | Serial bit clock |
| fsync_i | input | 1 | Frame sync |
| sdin_i | input | 1 | Serial data, MSB first |
| cfg_start_fall_i | input | 1 | Frame-start edge: 1 means high-to-low, 0 means low-to-high |
| cfg_cap_fall_i | input | 1 | Capture edge: 0 means rising, 1 means falling |
| cfg_offset_i | input | 5 | Bit clocks from the frame start to slot 0 |
| cfg_slot_len_i | input | 2 | Slot length code |
| cfg_word_len_i | input | 2 | Word length code |
| cfg_right_just_i | input | 1 | 1 places the word at the end of its slot |
| cfg_left_slot_i | input | 4 | Left slot index |
| cfg_right_slot_i | input | 4 | Right slot index |
| cfg_sel_i | input | 2 | Output select mode |
| strap_slot_i | input | 4 | Slot index used in select mode 00 |
| sample_o | output | 32 | Mono sample, MSB-aligned |
| sample_valid_o | output | 1 | One-cycle strobe for each finished frame |

## Verification
The assertions run on every cycle and cover the output handshake. The strobe must last one cycle and must follow a detected frame start. The sample must hold between strobes. When the word is 16 bits in a non-averaging mode, the low half of each strobed sample must be zero. Only the bench scenarios can show that the right bits were picked. This covers both start polarities and both capture edges, different offsets and slot and word lengths, right justification with clipping, the three select modes and the downmix, and the mute that applies at an exact frame boundary versus one bit beyond it.

// File: rtl/tdm_rx_pkg.sv
// Shared codes and length decoders for the TDM receive slot extractor.
// Assumes length codes are static while frames are received.
package tdm_rx_pkg;

    localparam int unsigned LEN_W = 6;

    typedef enum logic [1:0] {
        SEL_STRAP = 2'b00,
        SEL_LEFT  = 2'b01,
        SEL_RIGHT = 2'b10,
        SEL_MIX   = 2'b11
    } sel_mode_e;

    // Slot length in bits; reserved code decodes as 32.
    function automatic logic [LEN_W-1:0] slot_len_bits(input logic [1:0] code);
        case (code)
            2'b00:   return 6'd16;
            2'b01:   return 6'd24;
            default: return 6'd32;
        endcase
    endfunction

    // Word length in bits.
    function automatic logic [LEN_W-1:0] word_len_bits(input logic [1:0] code);
        case (code)
            2'b00:   return 6'd16;
            2'b01:   return 6'd20;
            2'b10:   return 6'd24;
            default: return 6'd32;
        endcase
    endfunction

    // Word length clipped to the slot length.
    function automatic logic [LEN_W-1:0] eff_word_bits(input logic [1:0] slen_code,
                                                       input logic [1:0] wlen_code);
        logic [LEN_W-1:0] s;
        logic [LEN_W-1:0] w;
        s = slot_len_bits(slen_code);
        w = word_len_bits(wlen_code);
        return (w > s) ? s : w;
    endfunction

endpackage

// File: rtl/tdm_rx_framer.sv
// Oversamples bit clock, frame sync and data on the system clock,
// detects the chosen capture edge and the chosen frame-start transition,
// and numbers bits from the frame start (position 0).
// Assumes the bit clock runs at most at a quarter of clk and that
// frame sync and data are stable around the capture edge.
module tdm_rx_framer #(
    parameter int unsigned POS_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bclk_i,
    input  logic             fsync_i,
    input  logic             sdin_i,
    input  logic             start_fall_i,
    input  logic             cap_fall_i,
    output logic             cap_en_o,
    output logic             bit_o,
    output logic [POS_W-1:0] pos_o,
    output logic             start_o,
    output logic             seen_o,
    output logic [POS_W:0]   frame_len_o
);

    localparam logic [POS_W-1:0] POS_MAX = '1;

    logic             bclk_q;
    logic             bclk_d;
    logic             fsync_q;
    logic             sdin_q;
    logic             fsync_cap;
    logic             seen_q;
    logic [POS_W-1:0] pos_q;

    // Input sampling stage and bit-clock history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bclk_q  <= 1'b0;
            bclk_d  <= 1'b0;
            fsync_q <= 1'b0;
            sdin_q  <= 1'b0;
        end else begin
            bclk_q  <= bclk_i;
            bclk_d  <= bclk_q;
            fsync_q <= fsync_i;
            sdin_q  <= sdin_i;
        end
    end

    // Capture edge, frame start and next bit position.
    always_comb begin
        cap_en_o = cap_fall_i ? (bclk_d & ~bclk_q) : (~bclk_d & bclk_q);
        start_o  = cap_en_o & (start_fall_i ? (fsync_cap & ~fsync_q)
                                            : (~fsync_cap & fsync_q));
        if (start_o) begin
            pos_o = '0;
        end else if (pos_q == POS_MAX) begin
            pos_o = POS_MAX;
        end else begin
            pos_o = pos_q + 1'b1;
        end
        frame_len_o = {1'b0, pos_q} + {{POS_W{1'b0}}, 1'b1};
        bit_o       = sdin_q;
        seen_o      = seen_q;
    end

    // Per-capture-edge state: last frame sync, position, first-frame flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fsync_cap <= 1'b0;
            pos_q     <= POS_MAX;
            seen_q    <= 1'b0;
        end else if (cap_en_o) begin
            fsync_cap <= fsync_q;
            pos_q     <= pos_o;
            if (start_o) begin
                seen_q <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/tdm_rx_word_cap.sv
// Captures one word from one slot by position window, MSB first, and
// presents it MSB-aligned; zero when the slot overruns the frame.
// Assumes word_bits_i <= slot_bits_i <= SAMPLE_W and static configuration.
module tdm_rx_word_cap #(
    parameter int unsigned POS_W    = 11,
    parameter int unsigned OFFSET_W = 5,
    parameter int unsigned SLOT_W   = 4,
    parameter int unsigned SAMPLE_W = 32,
    parameter int unsigned LEN_W    = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cap_en_i,
    input  logic                bit_i,
    input  logic [POS_W-1:0]    pos_i,
    input  logic [OFFSET_W-1:0] offset_i,
    input  logic [SLOT_W-1:0]   slot_i,
    input  logic [LEN_W-1:0]    slot_bits_i,
    input  logic [LEN_W-1:0]    word_bits_i,
    input  logic                right_just_i,
    input  logic [POS_W:0]      frame_len_i,
    output logic [SAMPLE_W-1:0] word_o
);

    localparam int unsigned EXT_W = POS_W + 1;

    logic [EXT_W-1:0]    slot_first;
    logic [EXT_W-1:0]    slot_end;
    logic [EXT_W-1:0]    word_first;
    logic [EXT_W-1:0]    word_end;
    logic [EXT_W-1:0]    pos_ext;
    logic                in_window;
    logic                fits;
    logic [LEN_W:0]      shift_amt;
    logic [SAMPLE_W-1:0] shreg;
    logic [SAMPLE_W-1:0] aligned;

    // Slot and word bit windows, bounds test and alignment.
    always_comb begin
        slot_first = EXT_W'(offset_i) + EXT_W'(slot_i) * EXT_W'(slot_bits_i);
        slot_end   = slot_first + EXT_W'(slot_bits_i);
        word_first = slot_first + (right_just_i ? EXT_W'(slot_bits_i - word_bits_i)
                                                : {EXT_W{1'b0}});
        word_end   = word_first + EXT_W'(word_bits_i);
        pos_ext    = {1'b0, pos_i};
        in_window  = (pos_ext >= word_first) && (pos_ext < word_end);
        fits       = (slot_end <= frame_len_i);
        shift_amt  = (LEN_W+1)'(SAMPLE_W) - {1'b0, word_bits_i};
        aligned    = shreg << shift_amt;
        word_o     = fits ? aligned : '0;
    end

    // Shift in word bits while the position is inside the window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '0;
        end else if (cap_en_i && in_window) begin
            shreg <= {shreg[SAMPLE_W-2:0], bit_i};
        end
    end

endmodule

// File: rtl/tdm_rx_mixer.sv
// Picks the mono result from the two captured words and registers it
// with a one-cycle strobe. Assumes words are two's complement MSB-aligned.
module tdm_rx_mixer
    import tdm_rx_pkg::*;
#(
    parameter int unsigned SAMPLE_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                take_i,
    input  logic [1:0]          sel_i,
    input  logic [SAMPLE_W-1:0] left_i,
    input  logic [SAMPLE_W-1:0] right_i,
    output logic [SAMPLE_W-1:0] sample_o,
    output logic                valid_o
);

    logic [SAMPLE_W:0]   sum;
    logic [SAMPLE_W-1:0] pick;

    // Sign-extended sum and select.
    always_comb begin
        sum = {left_i[SAMPLE_W-1], left_i} + {right_i[SAMPLE_W-1], right_i};
        case (sel_mode_e'(sel_i))
            SEL_RIGHT: pick = right_i;
            SEL_MIX:   pick = SAMPLE_W'(sum >> 1);
            default:   pick = left_i;
        endcase
    end

    // Output register and strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sample_o <= '0;
            valid_o  <= 1'b0;
        end else begin
            valid_o <= take_i;
            if (take_i) begin
                sample_o <= pick;
            end
        end
    end

endmodule

// File: rtl/tdm_rx_slot_extract.sv
// Top of the TDM receive slot extractor: framer, two slot capture units
// (first one serves strap or left slot, second one the right slot) and
// the output mixer. Assumes configuration is static during reception.
module tdm_rx_slot_extract
    import tdm_rx_pkg::*;
#(
    parameter int unsigned OFFSET_W      = 5,
    parameter int unsigned SLOT_W        = 4,
    parameter int unsigned SAMPLE_W      = 32,
    parameter int unsigned MAX_SLOT_BITS = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bclk_i,
    input  logic                fsync_i,
    input  logic                sdin_i,
    input  logic                cfg_start_fall_i,
    input  logic                cfg_cap_fall_i,
    input  logic [OFFSET_W-1:0] cfg_offset_i,
    input  logic [1:0]          cfg_slot_len_i,
    input  logic [1:0]          cfg_word_len_i,
    input  logic                cfg_right_just_i,
    input  logic [SLOT_W-1:0]   cfg_left_slot_i,
    input  logic [SLOT_W-1:0]   cfg_right_slot_i,
    input  logic [1:0]          cfg_sel_i,
    input  logic [SLOT_W-1:0]   strap_slot_i,
    output logic [SAMPLE_W-1:0] sample_o,
    output logic                sample_valid_o
);

    localparam int unsigned POS_W   = $clog2((1 << OFFSET_W) + ((1 << SLOT_W) + 1) * MAX_SLOT_BITS) + 1;
    localparam int unsigned N_CHAN  = 2;

    logic                cap_en;
    logic                bit_s;
    logic [POS_W-1:0]    pos;
    logic                frame_start;
    logic                seen;
    logic [POS_W:0]      frame_len;
    logic [LEN_W-1:0]    slot_bits;
    logic [LEN_W-1:0]    word_bits;
    logic [SLOT_W-1:0]   slot_idx [N_CHAN];
    logic [SAMPLE_W-1:0] words    [N_CHAN];

    tdm_rx_framer #(
        .POS_W (POS_W)
    ) i_framer (
        .clk          (clk),
        .rst_n        (rst_n),
        .bclk_i       (bclk_i),
        .fsync_i      (fsync_i),
        .sdin_i       (sdin_i),
        .start_fall_i (cfg_start_fall_i),
        .cap_fall_i   (cfg_cap_fall_i),
        .cap_en_o     (cap_en),
        .bit_o        (bit_s),
        .pos_o        (pos),
        .start_o      (frame_start),
        .seen_o       (seen),
        .frame_len_o  (frame_len)
    );

    // Length decode and slot index routing per channel.
    always_comb begin
        slot_bits   = slot_len_bits(cfg_slot_len_i);
        word_bits   = eff_word_bits(cfg_slot_len_i, cfg_word_len_i);
        slot_idx[0] = (sel_mode_e'(cfg_sel_i) == SEL_STRAP) ? strap_slot_i : cfg_left_slot_i;
        slot_idx[1] = cfg_right_slot_i;
    end

    for (genvar g = 0; g < N_CHAN; g++) begin : g_chan
        tdm_rx_word_cap #(
            .POS_W    (POS_W),
            .OFFSET_W (OFFSET_W),
            .SLOT_W   (SLOT_W),
            .SAMPLE_W (SAMPLE_W),
            .LEN_W    (LEN_W)
        ) i_cap (
            .clk          (clk),
            .rst_n        (rst_n),
            .cap_en_i     (cap_en),
            .bit_i        (bit_s),
            .pos_i        (pos),
            .offset_i     (cfg_offset_i),
            .slot_i       (slot_idx[g]),
            .slot_bits_i  (slot_bits),
            .word_bits_i  (word_bits),
            .right_just_i (cfg_right_just_i),
            .frame_len_i  (frame_len),
            .word_o       (words[g])
        );
    end

    tdm_rx_mixer #(
        .SAMPLE_W (SAMPLE_W)
    ) i_mixer (
        .clk      (clk),
        .rst_n    (rst_n),
        .take_i   (frame_start & seen),
        .sel_i    (cfg_sel_i),
        .left_i   (words[0]),
        .right_i  (words[1]),
        .sample_o (sample_o),
        .valid_o  (sample_valid_o)
    );

endmodule

// File: rtl/tdm_rx_slot_extract_chk.sv
// Output-handshake checker for the TDM receive slot extractor, bound to the top.
module tdm_rx_slot_extract_chk
    import tdm_rx_pkg::*;
#(
    parameter int unsigned SAMPLE_W = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic                frame_start,
    input logic [1:0]          cfg_sel_i,
    input logic [1:0]          cfg_slot_len_i,
    input logic [1:0]          cfg_word_len_i,
    input logic [SAMPLE_W-1:0] sample_o,
    input logic                sample_valid_o
);

    logic [LEN_W-1:0] eff;

    // Effective word length seen by the checker.
    always_comb eff = eff_word_bits(cfg_slot_len_i, cfg_word_len_i);

    // R11
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sample_valid_o |=> !sample_valid_o);

    // R11
    strobe_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sample_valid_o |-> $past(frame_start));

    // R11
    sample_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sample_o) |-> sample_valid_o);

    // R6
    low_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_valid_o && cfg_sel_i != 2'b11 && eff == 6'd16) |-> (sample_o[15:0] == 16'h0000));

endmodule

bind tdm_rx_slot_extract tdm_rx_slot_extract_chk #(
    .SAMPLE_W (SAMPLE_W)
) i_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .frame_start    (frame_start),
    .cfg_sel_i      (cfg_sel_i),
    .cfg_slot_len_i (cfg_slot_len_i),
    .cfg_word_len_i (cfg_word_len_i),
    .sample_o       (sample_o),
    .sample_valid_o (sample_valid_o)
);

// File: tb/test_tdm_rx_slot_extract.sv
`timescale 1ns/1ps
module test_tdm_rx_slot_extract;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        bclk;
    logic        fsync;
    logic        sdin;
    logic        cfg_start_fall;
    logic        cfg_cap_fall;
    logic [4:0]  cfg_offset;
    logic [1:0]  cfg_slot_len;
    logic [1:0]  cfg_word_len;
    logic        cfg_right_just;
    logic [3:0]  cfg_left_slot;
    logic [3:0]  cfg_right_slot;
    logic [1:0]  cfg_sel;
    logic [3:0]  strap_slot;
    logic [31:0] sample;
    logic        valid;

    int          n_cmp   = 0;
    int          n_bad   = 0;
    int          strobes = 0;
    logic [31:0] last_sample = '0;
    bit          fr [0:1023];
    int          flen = 256;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    tdm_rx_slot_extract i_tdm_rx_slot_extract (
        .clk              (clk),
        .rst_n            (rst_n),
        .bclk_i           (bclk),
        .fsync_i          (fsync),
        .sdin_i           (sdin),
        .cfg_start_fall_i (cfg_start_fall),
        .cfg_cap_fall_i   (cfg_cap_fall),
        .cfg_offset_i     (cfg_offset),
        .cfg_slot_len_i   (cfg_slot_len),
        .cfg_word_len_i   (cfg_word_len),
        .cfg_right_just_i (cfg_right_just),
        .cfg_left_slot_i  (cfg_left_slot),
        .cfg_right_slot_i (cfg_right_slot),
        .cfg_sel_i        (cfg_sel),
        .strap_slot_i     (strap_slot),
        .sample_o         (sample),
        .sample_valid_o   (valid)
    );

    // Strobe monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (rst_n && valid) begin
            strobes++;
            last_sample = sample;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic int slen_of(input logic [1:0] c);
        return (c == 2'b00) ? 16 : (c == 2'b01) ? 24 : 32;
    endfunction

    function automatic int wlen_of(input logic [1:0] c);
        return (c == 2'b00) ? 16 : (c == 2'b01) ? 20 : (c == 2'b10) ? 24 : 32;
    endfunction

    function automatic logic [31:0] exp_word(input int idx);
        int sl;
        int wl;
        int we;
        int s;
        int ws;
        logic [63:0] w;
        sl = slen_of(cfg_slot_len);
        wl = wlen_of(cfg_word_len);
        we = (wl > sl) ? sl : wl;
        s  = int'(cfg_offset) + idx * sl;
        if (s + sl > flen) return 32'h0;
        ws = s + (cfg_right_just ? (sl - we) : 0);
        w  = '0;
        for (int i = 0; i < we; i++) w = {w[62:0], fr[ws + i]};
        w = w << (32 - we);
        return w[31:0];
    endfunction

    function automatic logic [31:0] exp_mono();
        logic [31:0] l;
        logic [31:0] r;
        longint      sum;
        case (cfg_sel)
            2'b00: return exp_word(int'(strap_slot));
            2'b01: return exp_word(int'(cfg_left_slot));
            2'b10: return exp_word(int'(cfg_right_slot));
            default: begin
                l   = exp_word(int'(cfg_left_slot));
                r   = exp_word(int'(cfg_right_slot));
                sum = longint'($signed(l)) + longint'($signed(r));
                sum = sum >>> 1;
                return sum[31:0];
            end
        endcase
    endfunction

    task automatic send_bit(input bit d, input bit fs);
        bclk  = cfg_cap_fall ? 1'b1 : 1'b0;
        sdin  = d;
        fsync = fs;
        repeat (2) @(negedge clk);
        bclk = ~bclk;
        repeat (2) @(negedge clk);
    endtask

    task automatic send_frames(input int n);
        for (int f = 0; f < n; f++) begin
            for (int p = 0; p < flen; p++) begin
                bit active;
                active = (p < flen / 2);
                send_bit(fr[p], cfg_start_fall ? !active : active);
            end
        end
    endtask

    // Fill a frame, send four copies, check strobes over the last two and the result.
    task automatic run_case(input string tag, input int len);
        int c0;
        flen = len;
        for (int p = 0; p < 1024; p++) fr[p] = bit'($urandom & 1);
        send_frames(2);
        c0 = strobes;
        send_frames(2);
        check({tag, " R11 strobe count"}, 32'(strobes - c0), 32'd2);
        check(tag, last_sample, exp_mono());
    endtask

    task automatic set_cfg(input bit sf, input bit cf, input int off, input logic [1:0] sl,
                           input logic [1:0] wl, input bit rj, input int ls, input int rs,
                           input logic [1:0] sel, input int st);
        cfg_start_fall = sf;
        cfg_cap_fall   = cf;
        cfg_offset     = 5'(off);
        cfg_slot_len   = sl;
        cfg_word_len   = wl;
        cfg_right_just = rj;
        cfg_left_slot  = 4'(ls);
        cfg_right_slot = 4'(rs);
        cfg_sel        = sel;
        strap_slot     = 4'(st);
    endtask

    task automatic t_reset();
        check("R1 reset sample", sample, 32'h0);
        check("R1 reset strobe", {31'h0, valid}, 32'h0);
    endtask

    task automatic t_default();
        set_cfg(1, 0, 1, 2'b10, 2'b10, 0, 0, 0, 2'b00, 2);
        run_case("R2 R3 R4 R8 R12 strap slot, fall start, rise capture, 256-bit frame", 256);
    endtask

    task automatic t_left_falling();
        set_cfg(0, 1, 0, 2'b00, 2'b00, 0, 5, 0, 2'b01, 0);
        run_case("R2 R3 R5 R8 left slot, rise start, fall capture, 16-bit slots", 128);
    endtask

    task automatic t_right_just();
        set_cfg(1, 0, 3, 2'b01, 2'b01, 1, 0, 3, 2'b10, 0);
        run_case("R4 R5 R6 R7 R8 R12 right slot, right justified 20 in 24", 192);
    endtask

    task automatic t_mix();
        set_cfg(0, 0, 1, 2'b10, 2'b11, 0, 1, 6, 2'b11, 0);
        run_case("R9 downmix 32-bit words", 256);
    endtask

    task automatic t_bound();
        set_cfg(1, 0, 1, 2'b10, 2'b10, 0, 3, 0, 2'b01, 0);
        run_case("R10 slot one bit past frame end mutes", 128);
        set_cfg(1, 0, 0, 2'b10, 2'b10, 0, 3, 0, 2'b01, 0);
        run_case("R10 slot ending on last bit kept", 128);
        set_cfg(1, 0, 1, 2'b10, 2'b10, 0, 0, 0, 2'b00, 7);
        run_case("R10 strap slot wholly past frame mutes", 128);
    endtask

    task automatic t_clip();
        set_cfg(1, 1, 2, 2'b00, 2'b10, 0, 4, 0, 2'b01, 0);
        run_case("R6 word clipped to 16-bit slot", 128);
    endtask

    task automatic t_quad();
        set_cfg(1, 0, 0, 2'b11, 2'b11, 0, 0, 1, 2'b10, 0);
        run_case("R5 R12 reserved slot code as 32, 2-slot 64-bit frame", 64);
    endtask

    initial begin
        rst_n = 1'b0;
        bclk  = 1'b0;
        sdin  = 1'b0;
        fsync = 1'b1;
        set_cfg(1, 0, 1, 2'b10, 2'b10, 0, 0, 0, 2'b00, 2);
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_default();
        t_left_falling();
        t_right_just();
        t_mix();
        t_bound();
        t_clip();
        t_quad();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished run");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule